// File: doc/BRIEF.md
# Transactional Cache-Line Conflict Tracker

This block follows a single hardware transaction over a small, parameterised set of tracked cache lines. While a transaction is open, every local load marks its line as read and every local store marks its line as written. Snooped remote accesses are compared against those marks. Any of these causes the transaction to be thrown away as a whole:

- a conflicting remote access,
- running out of tracking entries,
- eviction of a marked line,
- a disruptive event,
- an explicit abort command,
- opening more nested levels than allowed.

On an abort the block reports a one-hot cause together with the fallback handler address that was recorded at the outermost begin.

Nesting is flat. Inner begins and ends only move a depth counter. The outermost end commits. An abort at any depth drops everything and returns the depth to zero. On commit or abort, all read and write marks are flash-cleared in the same cycle, and a one-cycle pulse is given. The data array, buffering of speculative data and register rollback belong to the surrounding core.

All outputs are registered. The effect of the inputs sampled at one rising edge shows on the outputs right after that edge.

Top module: `txn_conflict_tracker`

## Requirements
- R1: After reset, depth_o is 0, commit_o, abort_o and flash_clear_o are low, and abort_reason_o and abort_code_o are 0.
- R2: tx_begin_i at depth 0 opens a transaction at depth 1 and records tx_handler_i. At depth 1 or more, tx_begin_i alone adds one to the depth. tx_begin_i and tx_end_i together at depth 1 or more leave the depth unchanged.
- R3: tx_end_i alone at depth 1 gives commit_o and flash_clear_o high for exactly one cycle, and depth returns to 0. At a greater depth it only subtracts one. tx_end_i and tx_abort_i at depth 0 have no effect.
- R4: Line identity is address bits [ADDR_W-1:6]. Two addresses in the same 64-byte line are the same line, so a remote access to any byte of a marked line counts as a hit.
- R5: A remote write hitting a line marked read or written aborts with reason conflict. A remote read aborts only if the line is marked written. A remote read of a line marked only read has no effect.
- R6: A load or store that needs a new entry when all ENTRIES entries are marked, or an eviction notice for a marked line, aborts with reason capacity. An eviction of an unmarked line has no effect.
- R7: tx_begin_i without tx_end_i at depth MAX_DEPTH aborts with reason nesting.
- R8: event_i while depth is nonzero aborts with reason event.
- R9: tx_abort_i while depth is nonzero aborts with reason explicit. abort_code_o then takes tx_abort_code_i. For any other reason, abort_code_o is 0.
- R10: An abort gives abort_o and flash_clear_o high for one cycle, handler_o equal to the recorded handler, and depth 0. No mark survives a commit or an abort.
- R11: abort_reason_o is one-hot: bit0 explicit, bit1 conflict, bit2 capacity, bit3 nesting, bit4 event. When several causes arrive in one cycle, the order of precedence is event, conflict, capacity, nesting, explicit. The reason and code hold until the next abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin_i | input | 1 | Begin (or nest) a transaction |
| tx_handler_i | input | HANDLER_W | Fallback handler address, captured at the outermost begin |
| tx_end_i | input | 1 | End one nesting level |
| tx_abort_i | input | 1 | Explicit abort command |
| tx_abort_code_i | input | CODE_W | User code for an explicit abort |
| ld_valid_i | input | 1 | Local load this cycle |
| ld_addr_i | input | ADDR_W | Load address |
| st_valid_i | input | 1 | Local store this cycle |
| st_addr_i | input | ADDR_W | Store address |
| snp_wr_valid_i | input | 1 | Snooped remote write |
| snp_wr_addr_i | input | ADDR_W | Remote write address |
| snp_rd_valid_i | input | 1 | Snooped remote read |
| snp_rd_addr_i | input | ADDR_W | Remote read address |
| event_i | input | 1 | Interrupt, pause, context switch or debug event |
| evict_valid_i | input | 1 | Cache is evicting a line |
| evict_addr_i | input | ADDR_W | Address of the evicted line |
| commit_o | output | 1 | One-cycle commit pulse |
| abort_o | output | 1 | One-cycle abort pulse |
| abort_reason_o | output | 5 | One-hot cause of the last abort |
| abort_code_o | output | CODE_W | User code of the last abort |
| handler_o | output | HANDLER_W | Recorded handler, valid with abort_o |
| depth_o | output | DEPTH_W | Current nesting depth |
| flash_clear_o | output | 1 | All speculative marks were cleared |

## Verification
The bench uses the following access patterns, each of which separates one case from another:

- Loads and stores to lines that are already marked are mixed with loads and stores to fresh lines. This distinguishes a hit on an existing entry from an allocation.
- Remote reads are aimed at a line marked only read and at a line marked written. This shows whether the read-versus-write rule is applied.
- Remote accesses land on other bytes of a marked line and on the neighbouring line. This tells whether the 6 low address bits are really ignored.
- Lines are filled up to the entry count and then one further line is touched, and evictions are aimed at marked and unmarked lines. These show where capacity ends.
- Nested begin and end sequences, several causes in one cycle, and reuse of previously marked addresses after a commit or an abort check the depth rules, the order of precedence and the flash clear.

// File: rtl/txn_tracker_pkg.sv
package txn_tracker_pkg;

   localparam int REASON_W = 5;
   localparam int RSN_EXPLICIT = 0;
   localparam int RSN_CONFLICT = 1;
   localparam int RSN_CAPACITY = 2;
   localparam int RSN_NESTING  = 3;
   localparam int RSN_EVENT    = 4;

   typedef logic [REASON_W-1:0] reason_t;

   // One-hot cause; precedence event > conflict > capacity > nesting > explicit
   function automatic reason_t pick_reason(input logic ev, input logic cf,
                                           input logic cp, input logic ns,
                                           input logic ex);
      reason_t r;
      r = '0;
      if (ev)      r[RSN_EVENT]    = 1'b1;
      else if (cf) r[RSN_CONFLICT] = 1'b1;
      else if (cp) r[RSN_CAPACITY] = 1'b1;
      else if (ns) r[RSN_NESTING]  = 1'b1;
      else if (ex) r[RSN_EXPLICIT] = 1'b1;
      return r;
   endfunction

endpackage

// File: rtl/txn_line_table.sv
module txn_line_table #(
   parameter int ADDR_W   = 32,
   parameter int LINE_OFS = 6,
   parameter int ENTRIES  = 8,
   localparam int TAG_W   = ADDR_W - LINE_OFS,
   localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              mark_en_i,
   input  logic              ld_v_i,
   input  logic [ADDR_W-1:0] ld_addr_i,
   input  logic              st_v_i,
   input  logic [ADDR_W-1:0] st_addr_i,
   input  logic              snw_v_i,
   input  logic [ADDR_W-1:0] snw_addr_i,
   input  logic              snr_v_i,
   input  logic [ADDR_W-1:0] snr_addr_i,
   input  logic              ev_v_i,
   input  logic [ADDR_W-1:0] ev_addr_i,
   output logic              conflict_o,
   output logic              capacity_o
);

   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [ENTRIES-1:0] rd_q, wr_q, valid;
   logic [ENTRIES-1:0] ld_hit_v, st_hit_v, snw_hit_v, snr_hit_v, ev_hit_v;
   logic [ENTRIES-1:0] rd_set, wr_set;
   logic [TAG_W-1:0]   ld_tag, st_tag, snw_tag, snr_tag, ev_tag;
   logic               ld_hit, st_hit, ld_need, st_need, same_new;
   logic               has_f1, has_f2, no_room;
   logic [IDX_W-1:0]   f1, f2, st_slot;

   assign ld_tag  = ld_addr_i[ADDR_W-1:LINE_OFS];
   assign st_tag  = st_addr_i[ADDR_W-1:LINE_OFS];
   assign snw_tag = snw_addr_i[ADDR_W-1:LINE_OFS];
   assign snr_tag = snr_addr_i[ADDR_W-1:LINE_OFS];
   assign ev_tag  = ev_addr_i[ADDR_W-1:LINE_OFS];

   // an entry is in use exactly while it carries a read or write mark
   assign valid = rd_q | wr_q;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      assign ld_hit_v[g]  = valid[g] && (tag_q[g] == ld_tag);
      assign st_hit_v[g]  = valid[g] && (tag_q[g] == st_tag);
      assign snw_hit_v[g] = valid[g] && (tag_q[g] == snw_tag);
      assign snr_hit_v[g] = wr_q[g]  && (tag_q[g] == snr_tag);
      assign ev_hit_v[g]  = valid[g] && (tag_q[g] == ev_tag);
   end

   assign ld_hit   = |ld_hit_v;
   assign st_hit   = |st_hit_v;
   assign ld_need  = ld_v_i && !ld_hit;
   assign same_new = ld_need && st_v_i && !st_hit && (ld_tag == st_tag);
   assign st_need  = st_v_i && !st_hit && !same_new;
   assign st_slot  = ld_need ? f2 : f1;

   // lowest two free entries
   always_comb begin
      has_f1 = 1'b0;
      f1     = '0;
      has_f2 = 1'b0;
      f2     = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid[i]) begin
            has_f1 = 1'b1;
            f1     = IDX_W'(i);
         end
      end
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid[i] && (IDX_W'(i) != f1)) begin
            has_f2 = 1'b1;
            f2     = IDX_W'(i);
         end
      end
   end

   assign no_room = (ld_need && !has_f1) ||
                    (st_need && (ld_need ? !has_f2 : !has_f1));

   assign conflict_o = (snw_v_i && (|snw_hit_v)) || (snr_v_i && (|snr_hit_v));
   assign capacity_o = no_room || (ev_v_i && (|ev_hit_v));

   always_comb begin
      rd_set = '0;
      wr_set = '0;
      if (ld_v_i) begin
         if (ld_hit) rd_set = ld_hit_v;
         else        rd_set[f1] = 1'b1;
      end
      if (st_v_i) begin
         if (st_hit)        wr_set = st_hit_v;
         else if (same_new) wr_set[f1] = 1'b1;
         else               wr_set[st_slot] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         rd_q <= '0;
         wr_q <= '0;
      end else if (mark_en_i) begin
         rd_q <= rd_q | rd_set;
         wr_q <= wr_q | wr_set;
      end
   end

   always_ff @(posedge clk) begin
      if (mark_en_i && ld_need) tag_q[f1]      <= ld_tag;
      if (mark_en_i && st_need) tag_q[st_slot] <= st_tag;
   end

endmodule

// File: rtl/txn_nest_ctrl.sv
module txn_nest_ctrl
   import txn_tracker_pkg::*;
#(
   parameter int MAX_DEPTH = 4,
   parameter int HANDLER_W = 32,
   parameter int CODE_W    = 8,
   localparam int DEPTH_W  = $clog2(MAX_DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 begin_i,
   input  logic [HANDLER_W-1:0] handler_i,
   input  logic                 end_i,
   input  logic                 xabort_i,
   input  logic [CODE_W-1:0]    xcode_i,
   input  logic                 event_i,
   input  logic                 conflict_i,
   input  logic                 capacity_i,
   output logic                 clear_now_o,
   output logic                 mark_en_o,
   output logic                 commit_o,
   output logic                 abort_o,
   output logic                 flash_clear_o,
   output reason_t              reason_o,
   output logic [CODE_W-1:0]    code_o,
   output logic [HANDLER_W-1:0] handler_o,
   output logic [DEPTH_W-1:0]   depth_o
);

   logic [DEPTH_W-1:0] depth_q, depth_d;
   logic active, ex, ev, cf, cp, ns, abort_now, commit_now;
   reason_t rsn_now;

   assign active = (depth_q != '0);
   assign ex  = active && xabort_i;
   assign ev  = active && event_i;
   assign cf  = active && conflict_i;
   assign cp  = active && capacity_i;
   assign ns  = active && begin_i && !end_i && (depth_q == DEPTH_W'(MAX_DEPTH));

   assign abort_now  = ex || ev || cf || cp || ns;
   assign commit_now = active && !abort_now && end_i && !begin_i &&
                       (depth_q == DEPTH_W'(1));
   assign rsn_now    = pick_reason(ev, cf, cp, ns, ex);

   assign clear_now_o = abort_now || commit_now;
   assign mark_en_o   = active && !clear_now_o;

   always_comb begin
      depth_d = depth_q;
      if (!active) begin
         if (begin_i) depth_d = DEPTH_W'(1);
      end else if (clear_now_o) begin
         depth_d = '0;
      end else if (begin_i && !end_i) begin
         depth_d = depth_q + DEPTH_W'(1);
      end else if (end_i && !begin_i) begin
         depth_d = depth_q - DEPTH_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         depth_q       <= '0;
         commit_o      <= 1'b0;
         abort_o       <= 1'b0;
         flash_clear_o <= 1'b0;
         reason_o      <= '0;
         code_o        <= '0;
         handler_o     <= '0;
      end else begin
         depth_q       <= depth_d;
         commit_o      <= commit_now;
         abort_o       <= abort_now;
         flash_clear_o <= clear_now_o;
         if (abort_now) begin
            reason_o <= rsn_now;
            code_o   <= rsn_now[RSN_EXPLICIT] ? xcode_i : '0;
         end
         if (!active && begin_i) handler_o <= handler_i;
      end
   end

   assign depth_o = depth_q;

endmodule

// File: rtl/txn_conflict_tracker.sv
module txn_conflict_tracker
   import txn_tracker_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int LINE_OFS  = 6,
   parameter int ENTRIES   = 8,
   parameter int MAX_DEPTH = 4,
   parameter int HANDLER_W = 32,
   parameter int CODE_W    = 8,
   localparam int DEPTH_W  = $clog2(MAX_DEPTH + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tx_begin_i,
   input  logic [HANDLER_W-1:0] tx_handler_i,
   input  logic                 tx_end_i,
   input  logic                 tx_abort_i,
   input  logic [CODE_W-1:0]    tx_abort_code_i,
   input  logic                 ld_valid_i,
   input  logic [ADDR_W-1:0]    ld_addr_i,
   input  logic                 st_valid_i,
   input  logic [ADDR_W-1:0]    st_addr_i,
   input  logic                 snp_wr_valid_i,
   input  logic [ADDR_W-1:0]    snp_wr_addr_i,
   input  logic                 snp_rd_valid_i,
   input  logic [ADDR_W-1:0]    snp_rd_addr_i,
   input  logic                 event_i,
   input  logic                 evict_valid_i,
   input  logic [ADDR_W-1:0]    evict_addr_i,
   output logic                 commit_o,
   output logic                 abort_o,
   output logic [REASON_W-1:0]  abort_reason_o,
   output logic [CODE_W-1:0]    abort_code_o,
   output logic [HANDLER_W-1:0] handler_o,
   output logic [DEPTH_W-1:0]   depth_o,
   output logic                 flash_clear_o
);

   if (LINE_OFS < 1 || LINE_OFS >= ADDR_W) begin : g_bad_ofs
      $error("LINE_OFS must lie between 1 and ADDR_W-1");
   end
   if (ENTRIES < 2) begin : g_bad_entries
      $error("ENTRIES must be at least 2");
   end
   if (MAX_DEPTH < 1) begin : g_bad_depth
      $error("MAX_DEPTH must be at least 1");
   end

   logic conflict, capacity, clear_now, mark_en;

   txn_line_table #(
      .ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS), .ENTRIES(ENTRIES)
   ) u_table (
      .clk(clk), .rst_n(rst_n),
      .clear_i(clear_now), .mark_en_i(mark_en),
      .ld_v_i(ld_valid_i), .ld_addr_i(ld_addr_i),
      .st_v_i(st_valid_i), .st_addr_i(st_addr_i),
      .snw_v_i(snp_wr_valid_i), .snw_addr_i(snp_wr_addr_i),
      .snr_v_i(snp_rd_valid_i), .snr_addr_i(snp_rd_addr_i),
      .ev_v_i(evict_valid_i), .ev_addr_i(evict_addr_i),
      .conflict_o(conflict), .capacity_o(capacity)
   );

   txn_nest_ctrl #(
      .MAX_DEPTH(MAX_DEPTH), .HANDLER_W(HANDLER_W), .CODE_W(CODE_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .begin_i(tx_begin_i), .handler_i(tx_handler_i), .end_i(tx_end_i),
      .xabort_i(tx_abort_i), .xcode_i(tx_abort_code_i), .event_i(event_i),
      .conflict_i(conflict), .capacity_i(capacity),
      .clear_now_o(clear_now), .mark_en_o(mark_en),
      .commit_o(commit_o), .abort_o(abort_o), .flash_clear_o(flash_clear_o),
      .reason_o(abort_reason_o), .code_o(abort_code_o),
      .handler_o(handler_o), .depth_o(depth_o)
   );

endmodule

// File: rtl/txn_tracker_chk.sv
module txn_tracker_chk #(
   parameter int MAX_DEPTH = 4,
   parameter int HANDLER_W = 32,
   parameter int CODE_W    = 8,
   localparam int DEPTH_W  = $clog2(MAX_DEPTH + 1)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 tx_begin_i,
   input logic                 event_i,
   input logic                 commit_o,
   input logic                 abort_o,
   input logic [4:0]           abort_reason_o,
   input logic [DEPTH_W-1:0]   depth_o
);

   // R10
   abort_depth_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> (depth_o == '0) && !commit_o);

   // R10
   abort_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |=> !abort_o);

   // R3
   commit_depth_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> (depth_o == '0));

   // R11
   reason_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> ($countones(abort_reason_o) == 1));

   // R8
   event_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (depth_o != '0 && event_i) |=> (abort_o && abort_reason_o[4]));

   // R7
   depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      depth_o <= DEPTH_W'(MAX_DEPTH));

   // R3
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (depth_o == '0 && !tx_begin_i) |=> (depth_o == '0 && !abort_o && !commit_o));

endmodule

bind txn_conflict_tracker txn_tracker_chk #(
   .MAX_DEPTH(MAX_DEPTH), .HANDLER_W(HANDLER_W), .CODE_W(CODE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_begin_i(tx_begin_i), .event_i(event_i),
   .commit_o(commit_o), .abort_o(abort_o), .abort_reason_o(abort_reason_o),
   .depth_o(depth_o)
);

// File: tb/txn_conflict_tracker_bench.sv
module txn_conflict_tracker_bench;

   localparam int AW = 32, ENT = 8, MAXD = 4, HW = 32, CW = 8;
   localparam int DW = $clog2(MAXD + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   logic tx_begin, tx_end, tx_abort, ld_v, st_v, snw_v, snr_v, ev_in, evict_v;
   logic [HW-1:0] handler_in;
   logic [CW-1:0] code_in;
   logic [AW-1:0] ld_a, st_a, snw_a, snr_a, evict_a;
   logic commit, abort_p, fclear;
   logic [4:0] reason;
   logic [CW-1:0] code_out;
   logic [HW-1:0] handler_out;
   logic [DW-1:0] depth;

   always #4 clk = ~clk;

   txn_conflict_tracker u_txn_conflict_tracker (
      .clk(clk), .rst_n(rst_n),
      .tx_begin_i(tx_begin), .tx_handler_i(handler_in), .tx_end_i(tx_end),
      .tx_abort_i(tx_abort), .tx_abort_code_i(code_in),
      .ld_valid_i(ld_v), .ld_addr_i(ld_a), .st_valid_i(st_v), .st_addr_i(st_a),
      .snp_wr_valid_i(snw_v), .snp_wr_addr_i(snw_a),
      .snp_rd_valid_i(snr_v), .snp_rd_addr_i(snr_a),
      .event_i(ev_in), .evict_valid_i(evict_v), .evict_addr_i(evict_a),
      .commit_o(commit), .abort_o(abort_p), .abort_reason_o(reason),
      .abort_code_o(code_out), .handler_o(handler_out), .depth_o(depth),
      .flash_clear_o(fclear)
   );

   // behavioural reference: line number -> {read, write}
   bit [1:0]  m_line [int];
   int        m_depth;
   logic [HW-1:0] m_handler;
   logic [4:0] m_reason;
   logic [CW-1:0] m_code;
   bit e_commit, e_abort;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
      end
   endtask

   task automatic idle();
      tx_begin = 0; tx_end = 0; tx_abort = 0; ld_v = 0; st_v = 0;
      snw_v = 0; snr_v = 0; ev_in = 0; evict_v = 0;
      handler_in = '0; code_in = '0;
      ld_a = '0; st_a = '0; snw_a = '0; snr_a = '0; evict_a = '0;
   endtask

   function automatic bit has(input int l);
      return m_line.exists(l);
   endfunction

   task automatic model();
      int ll, sl, need;
      bit ev, cf, cp, ns, ex;
      ll = int'(ld_a >> 6);
      sl = int'(st_a >> 6);
      e_commit = 0;
      e_abort = 0;
      if (m_depth == 0) begin
         if (tx_begin) begin
            m_depth = 1;
            m_handler = handler_in;
         end
      end else begin
         ev = ev_in;
         cf = (snw_v && has(int'(snw_a >> 6))) ||
              (snr_v && has(int'(snr_a >> 6)) && m_line[int'(snr_a >> 6)][0]);
         need = 0;
         if (ld_v && !has(ll)) need++;
         if (st_v && !has(sl) && !(ld_v && ll == sl)) need++;
         cp = (evict_v && has(int'(evict_a >> 6))) || (m_line.num() + need > ENT);
         ns = tx_begin && !tx_end && m_depth == MAXD;
         ex = tx_abort;
         if (ev || cf || cp || ns || ex) begin
            e_abort = 1;
            m_reason = ev ? 5'b10000 : cf ? 5'b00010 : cp ? 5'b00100 :
                       ns ? 5'b01000 : 5'b00001;
            m_code = (m_reason == 5'b00001) ? code_in : '0;
            m_line.delete();
            m_depth = 0;
         end else if (tx_end && !tx_begin && m_depth == 1) begin
            e_commit = 1;
            m_line.delete();
            m_depth = 0;
         end else begin
            if (tx_begin && !tx_end) m_depth++;
            if (tx_end && !tx_begin) m_depth--;
            if (ld_v) m_line[ll] = (has(ll) ? m_line[ll] : 2'b00) | 2'b10;
            if (st_v) m_line[sl] = (has(sl) ? m_line[sl] : 2'b00) | 2'b01;
         end
      end
   endtask

   task automatic step(input string tag);
      model();
      @(posedge clk);
      #1;
      chk(depth == DW'(m_depth), tag, "depth", depth, m_depth);
      chk(commit == e_commit, tag, "commit", commit, e_commit);
      chk(abort_p == e_abort, tag, "abort", abort_p, e_abort);
      chk(fclear == (e_commit | e_abort), tag, "flash_clear", fclear, e_commit | e_abort);
      chk(reason == m_reason, tag, "reason", reason, m_reason);
      chk(code_out == m_code, tag, "code", code_out, m_code);
      if (e_abort) chk(handler_out == m_handler, tag, "handler", handler_out, m_handler);
      idle();
   endtask

   task automatic start(input string tag, input logic [HW-1:0] h);
      tx_begin = 1; handler_in = h;
      step(tag);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R1 watchdog act=hung exp=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      idle();
      m_depth = 0; m_handler = '0; m_reason = '0; m_code = '0;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk(depth == 0 && !commit && !abort_p && !fclear, "R1", "ctl", depth, 0);
      chk(reason == 0 && code_out == 0, "R1", "reason/code", reason, 0);
      rst_n = 1;

      // R3 end and explicit abort ignored while idle
      tx_end = 1; step("R3");
      tx_abort = 1; code_in = 8'h33; step("R3");

      // R2/R5 marks and remote reads
      start("R2", 32'h1000);
      ld_v = 1; ld_a = 32'h40; step("R5");
      ld_v = 1; ld_a = 32'h44; st_v = 1; st_a = 32'h80; step("R5");
      snr_v = 1; snr_a = 32'h7F; step("R5");          // only read-marked: no abort
      snr_v = 1; snr_a = 32'h8C; step("R5");          // written line: conflict
      step("R11");

      // R4 granularity
      start("R4", 32'h2000);
      ld_v = 1; ld_a = 32'h200; step("R4");
      snw_v = 1; snw_a = 32'h240; step("R4");         // neighbour line
      snw_v = 1; snw_a = 32'h23F; step("R4");         // same line, other byte

      // R2/R3/R7 nesting
      start("R2", 32'h3000);
      tx_begin = 1; step("R2");
      tx_begin = 1; step("R2");
      tx_begin = 1; step("R2");
      tx_begin = 1; tx_end = 1; step("R2");
      tx_end = 1; step("R3");
      tx_end = 1; step("R3");
      tx_end = 1; step("R3");
      tx_end = 1; step("R3");                          // outermost: commit
      start("R7", 32'h3100);
      for (int i = 0; i < MAXD - 1; i++) begin tx_begin = 1; step("R7"); end
      tx_begin = 1; step("R7");                        // overflow

      // R6 capacity by filling
      start("R6", 32'h4000);
      for (int i = 0; i < ENT; i++) begin
         ld_v = 1; ld_a = 32'h10000 + 32'(i) * 32'h40; step("R6");
      end
      ld_v = 1; ld_a = 32'h10004; step("R6");         // hit, no new entry
      st_v = 1; st_a = 32'h20000; step("R6");         // no room
      // R6 capacity by eviction
      start("R6", 32'h4100);
      st_v = 1; st_a = 32'h500; ld_v = 1; ld_a = 32'h540; step("R6");
      evict_v = 1; evict_a = 32'h600; step("R6");     // unmarked line
      evict_v = 1; evict_a = 32'h510; step("R6");     // marked line

      // R8 event
      start("R8", 32'h5000);
      ev_in = 1; step("R8");

      // R9 explicit with code, R11 hold
      start("R9", 32'h6000);
      tx_abort = 1; code_in = 8'hA5; step("R9");
      step("R11"); step("R11");

      // R11 precedence
      start("R11", 32'h7000);
      st_v = 1; st_a = 32'h900; step("R11");
      ev_in = 1; tx_abort = 1; code_in = 8'h11; snw_v = 1; snw_a = 32'h900; step("R11");
      start("R11", 32'h7100);
      ld_v = 1; ld_a = 32'hA00; step("R11");
      tx_abort = 1; code_in = 8'h22; snw_v = 1; snw_a = 32'hA00; step("R11");

      // R10 marks cleared after abort and after commit
      start("R10", 32'h8000);
      st_v = 1; st_a = 32'hB00; step("R10");
      tx_abort = 1; code_in = 8'h01; step("R10");
      start("R10", 32'h8100);
      snw_v = 1; snw_a = 32'hB00; step("R10");        // old mark gone
      st_v = 1; st_a = 32'hC00; step("R10");
      tx_end = 1; step("R10");
      start("R10", 32'h8200);
      snr_v = 1; snr_a = 32'hC00; step("R10");
      ev_in = 1; step("R10");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule